// File: doc/BRIEF.md
# Exception Entry and Status Controller

This block owns the processor's current status word and the five saved status words that belong to the exception modes (fast interrupt, normal interrupt, supervisor, abort, undefined). Each exception type has its own request line. When a request wins arbitration, the block does the whole entry at one clock edge. It stores the outgoing status word in the saved register of the mode being entered. It clears the 16-bit state bit, switches the mode and raises the interrupt masks. It then reports the return address for the banked link register and the new program counter taken from the vector table.

An exception return request reloads the status word from the current mode's saved register and sends the fetch unit to the supplied link value. Software can write the current status word and the current mode's saved word, within the limits set by privilege. The register file and instruction fetch sit outside the block. The block only gives them the link value, a link-write strobe and a one-cycle redirect.

The control is a four-state machine. S_BOOT is held during reset and issues the reset redirect. S_RUN is the only state that accepts requests and software writes. S_ENTER is the one-cycle entry redirect with the link write. S_RETURN is the one-cycle return redirect. The transitions are: S_BOOT to S_RUN always; S_RUN to S_ENTER when an exception is taken; S_RUN to S_RETURN when a return is accepted; S_ENTER and S_RETURN to S_RUN always.

Top module: `esc_status_ctrl`

## Requirements
- R1: During and after reset the status word reads 0x000000D3: Supervisor mode, IRQ mask I (bit 7) and FIQ mask F (bit 6) set, state bit T (bit 5) clear. For the first cycle after reset, redir_valid is 1, redir_pc equals the vector base and link_we is 0.
- R2: The vector is base + offset. The offsets are reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18 and FIQ 0x1C. No entry ever uses 0x14.
- R3: The mode field is bits 4:0. Reset and software interrupt enter Supervisor (10011). Both aborts enter Abort (10111). Undefined enters Undefined (11011). IRQ enters IRQ (10010). FIQ enters FIQ (10001). The other codes are User 10000 and System 11111.
- R4: Entry clears T and sets I. It also sets F for reset and FIQ and leaves F unchanged otherwise. Flags N Z C V Q (bits 31:27) and the other bits are kept. The cycle after the sampling edge shows redir_valid=1, link_we=1 and link_val equal to pc_cur from the sampling cycle.
- R5: Entry copies the old status word into the target mode's saved register. spsr_q always shows the saved register of the current mode.
- R6: Of simultaneous requests, the winner is the first present in this order: reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt.
- R7: An IRQ request while I=1 or an FIQ request while F=1 is ignored, and a lower request may win instead.
- R8: A return in a mode that has a saved register loads the status word from it and gives redir_pc=ret_link with redir_valid=1 and link_we=0 for one cycle. In User or System mode a return is ignored.
- R9: A software status write replaces the whole word in a privileged mode. In User mode it changes only bits 31:27.
- R10: A software saved-word write updates the current mode's saved register. In User or System mode it is ignored and spsr_q reads 0.
- R11: With hivec_en=1 the vector base is 0xFFFF0000 instead of 0x00000000.
- R12: Requests, returns and software writes are sampled only in S_RUN. In the same cycle an exception beats a return, and a return beats software writes. Each redirect lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hivec_en | input | 1 | Selects the high vector base |
| req_rst | input | 1 | Soft reset exception request |
| req_und | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_dabt | input | 1 | Data abort request |
| req_irq | input | 1 | Normal interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| pc_cur | input | 32 | Return address captured on entry |
| ret_req | input | 1 | Exception return request |
| ret_link | input | 32 | Program counter restored on return |
| sw_cpsr_we | input | 1 | Software write of the status word |
| sw_spsr_we | input | 1 | Software write of the current saved word |
| sw_wdata | input | 32 | Software write data |
| cpsr_q | output | 32 | Current status word |
| spsr_q | output | 32 | Saved word of the current mode (0 if none) |
| redir_valid | output | 1 | One-cycle program counter redirect |
| redir_pc | output | 32 | Redirect target |
| link_we | output | 1 | Write link_val to the banked link register |
| link_val | output | 32 | Link value for the entered mode |

## Verification
Some properties are checked on every cycle. Each entry leaves T clear and I set, and the new mode's saved word equals the word held one cycle earlier. FIQ entry always leaves F set. Vectors are word aligned and never the reserved slot. Redirects last one cycle. In User mode nothing below bit 27 changes except through an entry. Other behaviour shows only in the bench's scenarios: the priority order, masking, vector selection and base relocation, restores on return, and whether a saved-word write is ignored. Those scenarios put requests together, change privilege and then read each bank back through the ports.

// File: rtl/esc_pkg.sv
package esc_pkg;

    localparam int XLEN   = 32;
    localparam int NCAUSE = 7;
    localparam int CW     = $clog2(NCAUSE);
    localparam int NBANK  = 5;
    localparam int BW     = $clog2(NBANK);

    localparam int B_I = 7;
    localparam int B_F = 6;
    localparam int B_T = 5;

    localparam logic [4:0] M_USR = 5'b10000;
    localparam logic [4:0] M_FIQ = 5'b10001;
    localparam logic [4:0] M_IRQ = 5'b10010;
    localparam logic [4:0] M_SVC = 5'b10011;
    localparam logic [4:0] M_ABT = 5'b10111;
    localparam logic [4:0] M_UND = 5'b11011;
    localparam logic [4:0] M_SYS = 5'b11111;

    localparam logic [XLEN-1:0] RESET_WORD = XLEN'({1'b1, 1'b1, 1'b0, M_SVC});

    // cause index = arbitration rank, 0 wins
    localparam logic [CW-1:0] C_RST  = 3'd0;
    localparam logic [CW-1:0] C_DABT = 3'd1;
    localparam logic [CW-1:0] C_FIQ  = 3'd2;
    localparam logic [CW-1:0] C_IRQ  = 3'd3;
    localparam logic [CW-1:0] C_PABT = 3'd4;
    localparam logic [CW-1:0] C_UND  = 3'd5;
    localparam logic [CW-1:0] C_SWI  = 3'd6;

    typedef enum logic [1:0] {
        S_BOOT,
        S_RUN,
        S_ENTER,
        S_RETURN
    } fsm_e;

    function automatic logic [4:0] cause_mode(input logic [CW-1:0] c);
        unique case (c)
            C_RST, C_SWI:   return M_SVC;
            C_DABT, C_PABT: return M_ABT;
            C_FIQ:          return M_FIQ;
            C_IRQ:          return M_IRQ;
            default:        return M_UND;
        endcase
    endfunction

    function automatic logic [4:0] cause_offset(input logic [CW-1:0] c);
        unique case (c)
            C_RST:   return 5'h00;
            C_UND:   return 5'h04;
            C_SWI:   return 5'h08;
            C_PABT:  return 5'h0C;
            C_DABT:  return 5'h10;
            C_IRQ:   return 5'h18;
            default: return 5'h1C;
        endcase
    endfunction

    function automatic logic cause_masks_fiq(input logic [CW-1:0] c);
        return (c == C_RST) || (c == C_FIQ);
    endfunction

    function automatic logic mode_banked(input logic [4:0] m);
        return (m == M_FIQ) || (m == M_IRQ) || (m == M_SVC) ||
               (m == M_ABT) || (m == M_UND);
    endfunction

    function automatic logic [BW-1:0] mode_bank(input logic [4:0] m);
        unique case (m)
            M_FIQ:   return 3'd0;
            M_IRQ:   return 3'd1;
            M_SVC:   return 3'd2;
            M_ABT:   return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/esc_arbiter.sv
module esc_arbiter
    import esc_pkg::*;
#(
    parameter int N = NCAUSE
) (
    input  logic [N-1:0]  req,
    input  logic          irq_masked,
    input  logic          fiq_masked,
    output logic          any,
    output logic [CW-1:0] sel
);
    logic [N-1:0] eff;

    always_comb begin
        eff = req;
        eff[C_IRQ] = req[C_IRQ] & ~irq_masked;
        eff[C_FIQ] = req[C_FIQ] & ~fiq_masked;
    end

    always_comb begin
        any = |eff;
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eff[i]) sel = CW'(i);
        end
    end
endmodule

// File: rtl/esc_spsr_bank.sv
module esc_spsr_bank
    import esc_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int NB = NBANK
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [BW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic [BW-1:0] ridx,
    output logic [W-1:0]  rdata
);
    logic [NB*W-1:0] flat;

    for (genvar g = 0; g < NB; g++) begin : g_bank
        logic [W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (we && widx == BW'(g))
                q <= wdata;
        end
        assign flat[g*W +: W] = q;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NB; i++) begin
            if (ridx == BW'(i)) rdata = flat[i*W +: W];
        end
    end
endmodule

// File: rtl/esc_status_ctrl.sv
module esc_status_ctrl
    import esc_pkg::*;
#(
    parameter logic [XLEN-1:0] LOVEC_BASE = 32'h0000_0000,
    parameter logic [XLEN-1:0] HIVEC_BASE = 32'hFFFF_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hivec_en,
    input  logic            req_rst,
    input  logic            req_und,
    input  logic            req_swi,
    input  logic            req_pabt,
    input  logic            req_dabt,
    input  logic            req_irq,
    input  logic            req_fiq,
    input  logic [XLEN-1:0] pc_cur,
    input  logic            ret_req,
    input  logic [XLEN-1:0] ret_link,
    input  logic            sw_cpsr_we,
    input  logic            sw_spsr_we,
    input  logic [XLEN-1:0] sw_wdata,
    output logic [XLEN-1:0] cpsr_q,
    output logic [XLEN-1:0] spsr_q,
    output logic            redir_valid,
    output logic [XLEN-1:0] redir_pc,
    output logic            link_we,
    output logic [XLEN-1:0] link_val
);
    fsm_e            state_q, state_d;
    logic [XLEN-1:0] cpsr_r;
    logic [XLEN-1:0] redir_r;
    logic [XLEN-1:0] link_r;
    logic [NCAUSE-1:0] req_vec;
    logic            arb_any;
    logic [CW-1:0]   arb_sel;
    logic            in_run, cur_banked, priv;
    logic            take_exc, take_ret, sw_ok;
    logic [4:0]      tgt_mode;
    logic [XLEN-1:0] entry_word, vec_base, bank_rd, bank_wd;
    logic            bank_we;
    logic [BW-1:0]   bank_widx;

    assign req_vec = {req_swi, req_und, req_pabt, req_irq, req_fiq, req_dabt, req_rst};

    esc_arbiter #(.N(NCAUSE)) u_arb (
        .req        (req_vec),
        .irq_masked (cpsr_r[B_I]),
        .fiq_masked (cpsr_r[B_F]),
        .any        (arb_any),
        .sel        (arb_sel)
    );

    assign in_run     = (state_q == S_RUN);
    assign cur_banked = mode_banked(cpsr_r[4:0]);
    assign priv       = (cpsr_r[4:0] != M_USR);
    assign take_exc   = in_run && arb_any;
    assign take_ret   = in_run && !arb_any && ret_req && cur_banked;
    assign sw_ok      = in_run && !arb_any && !ret_req;
    assign tgt_mode   = cause_mode(arb_sel);
    assign vec_base   = hivec_en ? HIVEC_BASE : LOVEC_BASE;

    always_comb begin
        entry_word        = cpsr_r;
        entry_word[B_T]   = 1'b0;
        entry_word[B_I]   = 1'b1;
        entry_word[B_F]   = cpsr_r[B_F] | cause_masks_fiq(arb_sel);
        entry_word[4:0]   = tgt_mode;
    end

    assign bank_we   = take_exc || (sw_ok && sw_spsr_we && cur_banked);
    assign bank_widx = take_exc ? mode_bank(tgt_mode) : mode_bank(cpsr_r[4:0]);
    assign bank_wd   = take_exc ? cpsr_r : sw_wdata;

    esc_spsr_bank #(.W(XLEN), .NB(NBANK)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .widx  (bank_widx),
        .wdata (bank_wd),
        .ridx  (mode_bank(cpsr_r[4:0])),
        .rdata (bank_rd)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_BOOT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_BOOT:   state_d = S_RUN;
            S_RUN: begin
                if (take_exc)      state_d = S_ENTER;
                else if (take_ret) state_d = S_RETURN;
            end
            S_ENTER:  state_d = S_RUN;
            S_RETURN: state_d = S_RUN;
            default:  state_d = S_BOOT;
        endcase
    end

    // status word and captured redirect / link
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpsr_r  <= RESET_WORD;
            redir_r <= '0;
            link_r  <= '0;
        end else if (take_exc) begin
            cpsr_r  <= entry_word;
            redir_r <= vec_base | XLEN'(cause_offset(arb_sel));
            link_r  <= pc_cur;
        end else if (take_ret) begin
            cpsr_r  <= bank_rd;
            redir_r <= ret_link;
        end else if (sw_ok && sw_cpsr_we) begin
            cpsr_r  <= priv ? sw_wdata : {sw_wdata[31:27], cpsr_r[26:0]};
        end
    end

    // outputs
    always_comb begin
        redir_valid = 1'b0;
        link_we     = 1'b0;
        redir_pc    = redir_r;
        unique case (state_q)
            S_BOOT: begin
                redir_valid = 1'b1;
                redir_pc    = vec_base;
            end
            S_ENTER: begin
                redir_valid = 1'b1;
                link_we     = 1'b1;
            end
            S_RETURN: redir_valid = 1'b1;
            default: ;
        endcase
    end

    assign cpsr_q   = cpsr_r;
    assign spsr_q   = cur_banked ? bank_rd : '0;
    assign link_val = link_r;
endmodule

// File: rtl/esc_status_ctrl_chk.sv
module esc_status_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] cpsr_q,
    input logic [31:0] spsr_q,
    input logic        redir_valid,
    input logic [31:0] redir_pc,
    input logic        link_we
);
    p_entry_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (!cpsr_q[5] && cpsr_q[7]));

    p_entry_save_r5: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (spsr_q == $past(cpsr_q)));

    p_fiq_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (link_we && cpsr_q[4:0] == 5'b10001) |-> cpsr_q[6]);

    p_vec_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (redir_pc[1:0] == 2'b00 && redir_pc[4:0] != 5'h14));

    p_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> !redir_valid);

    p_user_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpsr_q[4:0] == 5'b10000) |=> (link_we || cpsr_q[26:0] == $past(cpsr_q[26:0])));
endmodule

bind esc_status_ctrl esc_status_ctrl_chk u_chk (.*);

// File: tb/tb_esc_status_ctrl.sv
module tb_esc_status_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hivec_en = 1'b0;
    logic [6:0]  reqs = '0;   // {swi,und,pabt,irq,fiq,dabt,rst}
    logic [31:0] pc_cur = '0;
    logic        ret_req = 1'b0;
    logic [31:0] ret_link = '0;
    logic        sw_cpsr_we = 1'b0;
    logic        sw_spsr_we = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] cpsr_q, spsr_q, redir_pc, link_val;
    logic        redir_valid, link_we;

    localparam logic [6:0] Q_RST = 7'b0000001, Q_DABT = 7'b0000010, Q_FIQ = 7'b0000100,
                           Q_IRQ = 7'b0001000, Q_PABT = 7'b0010000, Q_UND = 7'b0100000,
                           Q_SWI = 7'b1000000;

    always #4 clk = ~clk;

    esc_status_ctrl dut (
        .clk(clk), .rst_n(rst_n), .hivec_en(hivec_en),
        .req_rst(reqs[0]), .req_und(reqs[5]), .req_swi(reqs[6]), .req_pabt(reqs[4]),
        .req_dabt(reqs[1]), .req_irq(reqs[3]), .req_fiq(reqs[2]),
        .pc_cur(pc_cur), .ret_req(ret_req), .ret_link(ret_link),
        .sw_cpsr_we(sw_cpsr_we), .sw_spsr_we(sw_spsr_we), .sw_wdata(sw_wdata),
        .cpsr_q(cpsr_q), .spsr_q(spsr_q), .redir_valid(redir_valid), .redir_pc(redir_pc),
        .link_we(link_we), .link_val(link_val)
    );

    typedef struct {
        string       tag;
        logic [31:0] pc;
        logic        lw;
        logic [31:0] link;
        logic [31:0] cpsr;
        logic [31:0] spsr;
    } item_t;

    item_t q[$];
    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push(string tag, logic [31:0] pc, logic lw, logic [31:0] lk,
                        logic [31:0] cp, logic [31:0] sp);
        item_t it;
        it.tag = tag; it.pc = pc; it.lw = lw; it.link = lk; it.cpsr = cp; it.spsr = sp;
        q.push_back(it);
    endtask

    // monitor: every redirect must match the next expected item
    always @(negedge clk) begin
        if (rst_n && redir_valid) begin
            if (q.size() == 0) begin
                chk("R12 unexpected redirect", redir_pc, 32'hxxxxxxxx);
            end else begin
                item_t it;
                it = q.pop_front();
                chk({it.tag, " pc"}, redir_pc, it.pc);
                chk({it.tag, " link_we"}, 32'(link_we), 32'(it.lw));
                if (it.lw) chk({it.tag, " link"}, link_val, it.link);
                chk({it.tag, " cpsr"}, cpsr_q, it.cpsr);
                chk({it.tag, " spsr"}, spsr_q, it.spsr);
            end
        end
    end

    // one sampled cycle of stimulus, then one idle cycle
    task automatic drive(logic [6:0] r, logic ret, logic [31:0] pc, logic [31:0] lk,
                         logic cw, logic sw, logic [31:0] wd);
        reqs = r; ret_req = ret; pc_cur = pc; ret_link = lk;
        sw_cpsr_we = cw; sw_spsr_we = sw; sw_wdata = wd;
        @(posedge clk); @(negedge clk);
        reqs = '0; ret_req = 1'b0; sw_cpsr_we = 1'b0; sw_spsr_we = 1'b0;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic exc(string tag, logic [6:0] r, logic [31:0] pc, logic [31:0] vec,
                       logic [31:0] cp, logic [31:0] sp);
        push(tag, vec, 1'b1, pc, cp, sp);
        drive(r, 1'b0, pc, 32'h0, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic ret(string tag, logic [31:0] lk, logic [31:0] cp, logic [31:0] sp);
        push(tag, lk, 1'b0, 32'h0, cp, sp);
        drive('0, 1'b1, 32'h0, lk, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic wcpsr(logic [31:0] d);
        drive('0, 1'b0, 32'h0, 32'h0, 1'b1, 1'b0, d);
    endtask

    task automatic wspsr(logic [31:0] d);
        drive('0, 1'b0, 32'h0, 32'h0, 1'b0, 1'b1, d);
    endtask

    initial begin
        #(8 * 20000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state and boot redirect
        repeat (3) @(posedge clk);
        #1;
        chk("R1 cpsr in reset", cpsr_q, 32'h000000D3);
        push("R1 boot", 32'h0, 1'b0, 32'h0, 32'h000000D3, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        @(posedge clk); @(negedge clk);

        wcpsr(32'h00000013);
        chk("R9 privileged write", cpsr_q, 32'h00000013);

        exc("R4 R3 irq entry", Q_IRQ, 32'h100, 32'h18, 32'h00000092, 32'h00000013);
        ret("R8 return to svc", 32'h104, 32'h00000013, 32'h0);

        wcpsr(32'h80000033);
        exc("R4 fiq clears T sets F", Q_FIQ, 32'h200, 32'h1C, 32'h800000D1, 32'h80000033);
        exc("R7 masked irq fiq, pabt wins", Q_IRQ | Q_FIQ | Q_PABT, 32'h300, 32'h0C,
            32'h800000D7, 32'h800000D1);

        wcpsr(32'h00000013);
        exc("R6 dabt over fiq irq", Q_DABT | Q_FIQ | Q_IRQ, 32'h400, 32'h10,
            32'h00000097, 32'h00000013);
        ret("R8 return from abort", 32'h404, 32'h00000013, 32'h0);
        exc("R6 fiq over irq", Q_FIQ | Q_IRQ, 32'h500, 32'h1C, 32'h000000D1, 32'h00000013);
        ret("R8 return from fiq", 32'h504, 32'h00000013, 32'h0);
        exc("R6 R3 und over swi", Q_UND | Q_SWI, 32'h600, 32'h04, 32'h0000009B, 32'h00000013);
        ret("R8 return from und", 32'h604, 32'h00000013, 32'h0);
        exc("R2 swi", Q_SWI, 32'h700, 32'h08, 32'h00000093, 32'h00000013);
        ret("R5 return from swi", 32'h704, 32'h00000013, 32'h00000013);

        hivec_en = 1'b1;
        exc("R11 high vector irq", Q_IRQ, 32'h800, 32'hFFFF0018, 32'h00000092, 32'h00000013);
        hivec_en = 1'b0;
        ret("R8 return hivec", 32'h804, 32'h00000013, 32'h00000013);

        exc("R6 reset wins", Q_RST | Q_DABT | Q_IRQ, 32'h900, 32'h00, 32'h000000D3,
            32'h00000013);

        wcpsr(32'h00000010);
        chk("R9 enter user", cpsr_q, 32'h00000010);
        chk("R10 user spsr reads 0", spsr_q, 32'h0);
        wcpsr(32'hF00000DF);
        chk("R9 user writes flags only", cpsr_q, 32'hF0000010);
        wspsr(32'h00000055);
        chk("R10 user spsr write ignored", spsr_q, 32'h0);

        // return in user mode must not redirect
        ret_req = 1'b1; ret_link = 32'h999;
        @(posedge clk); @(negedge clk);
        ret_req = 1'b0;
        chk("R8 user return ignored", 32'(redir_valid), 32'h0);
        chk("R8 user cpsr kept", cpsr_q, 32'hF0000010);
        @(posedge clk); @(negedge clk);

        exc("R5 irq from user", Q_IRQ, 32'hA00, 32'h18, 32'hF0000092, 32'hF0000010);
        wspsr(32'h0000001F);
        chk("R10 spsr write in irq", spsr_q, 32'h0000001F);
        ret("R8 return to system", 32'hA04, 32'h0000001F, 32'h0);
        wspsr(32'h000000AA);
        chk("R10 system spsr reads 0", spsr_q, 32'h0);
        wcpsr(32'h00000092);
        chk("R10 system write left irq bank", spsr_q, 32'h0000001F);

        // exception and return in the same cycle: exception wins
        push("R12 exc beats return", 32'h1C, 1'b1, 32'hB00, 32'h000000D1, 32'h00000092);
        drive(Q_FIQ, 1'b1, 32'hB00, 32'hBBB, 1'b0, 1'b0, 32'h0);

        chk("R12 queue drained", 32'(q.size()), 32'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule